// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block sits between a byte-wide receive stream and system memory. It places each incoming Ethernet frame into a ring of fixed-size 128-byte buffers. A two-word descriptor describes each buffer. The first word holds the buffer address, an ownership flag and a wrap flag. The second word holds status: frame boundaries, the total frame length and the address-match class.

The block follows a ring pointer. Software supplies the pointer's base, and the block reloads it each time reception is switched on. Before it uses a descriptor, the block fetches its first word from a descriptor memory with one cycle of read latency. It writes each frame byte to the buffer through a byte write port. When a buffer fills, or the frame ends, the block hands the buffer to software. It writes the status word first and then the address word with the ownership flag set. If a descriptor is still owned by software when the block needs it, the rest of the frame is thrown away and a sticky flag is raised.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset, `in_ready`, `desc_rd_en`, `desc_wr_en`, `buf_wr_en` and `no_buf_sticky` are all 0.
- R2: When `rx_en` goes from 0 to 1, the ring pointer and the stored wrap target are loaded from `ring_base`. The next descriptor fetched is the one at that address.
- R3: Byte k of a buffer (k = 0..127) is written to the word-0 address with bits 1:0 forced to zero, plus k. Data bytes are written only while `in_valid` and `in_ready` are both high.
- R4: Descriptors lie 8 bytes apart: word 0 at the pointer and word 1 at pointer+4. A frame longer than 128 bytes continues in the next descriptor.
- R5: Word 1 written back has bit 14 set in the first buffer of a frame and bit 15 set in the last. Bits 11:0 hold the whole frame length in the last buffer and 0 in every other buffer.
- R6: In the last buffer only, word 1 bit 31 = `in_bcast`, bits 26,25,24,23 = `in_addr_hit[0..3]`, and bit 22 = `in_type_hit`. All are sampled with the final byte.
- R7: Word 0 is written back as the fetched word with bit 0 set. This happens in the cycle right after the word-1 write of the same descriptor.
- R8: After a descriptor whose word 0 bit 1 is set, the next descriptor used is the one at the stored ring base.
- R9: If the descriptor fetched at frame start has bit 0 set, the whole frame is consumed without any buffer or descriptor write, and `no_buf_sticky` becomes 1. `no_buf_sticky` stays 1 until the next rising edge of `rx_en`.
- R10: If the descriptor fetched in the middle of a frame has bit 0 set, the rest of the frame is dropped and `no_buf_sticky` becomes 1. The buffers already written keep their ownership bit and show a start flag with no end flag.
- R11: A frame that ends part-way through a buffer leaves the rest of that buffer unused. The next frame starts in the next descriptor.
- R12: While `rx_en` is 0 between frames, `in_ready` stays 0 and no descriptor is read or written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Reception enable; a rising edge reloads the ring pointer |
| ring_base | input | AW | Byte address of the first descriptor |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_bcast | input | 1 | Frame has a broadcast destination (valid with last byte) |
| in_addr_hit | input | 4 | Specific-address match 1..4 (valid with last byte) |
| in_type_hit | input | 1 | Type-ID match (valid with last byte) |
| in_ready | output | 1 | Block accepts a byte this cycle |
| desc_rd_en | output | 1 | Descriptor word 0 read request |
| desc_rd_addr | output | AW | Descriptor read byte address |
| desc_rd_data | input | 32 | Read data, valid one cycle after the request |
| desc_wr_en | output | 1 | Descriptor word write |
| desc_wr_addr | output | AW | Descriptor write byte address |
| desc_wr_data | output | 32 | Descriptor write data |
| buf_wr_en | output | 1 | Buffer byte write |
| buf_wr_addr | output | 32 | Buffer byte address |
| buf_wr_data | output | 8 | Buffer byte |
| no_buf_sticky | output | 1 | Sticky flag: a frame was dropped because no buffer was available |

## Verification
The checker assumes `ring_base` is a multiple of 8. It uses address bit 2 to tell status writes from address writes, and it checks read alignment on the same basis. It also assumes `rx_en` is low during reset, so the first edge after reset is not taken for a rising edge, and that `rx_en` changes only between frames. The stimulus uses ring bases 0 and 8 only. It holds `rx_en` low through reset and toggles it only after a frame's write-back has finished.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CHECK,
        ST_DATA,
        ST_WB_STAT,
        ST_WB_OWN,
        ST_DROP
    } rxr_state_e;

    localparam int unsigned OWN_BIT   = 0;
    localparam int unsigned WRAP_BIT  = 1;
    localparam int unsigned SOF_BIT   = 14;
    localparam int unsigned EOF_BIT   = 15;
    localparam int unsigned TYPE_BIT  = 22;
    localparam int unsigned HIT1_BIT  = 26;
    localparam int unsigned BCAST_BIT = 31;
    localparam int unsigned HIT_N     = 4;

    typedef struct packed {
        logic             bcast;
        logic [HIT_N-1:0] hit;
        logic             type_hit;
    } rxr_class_t;

endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
    parameter int unsigned AW     = 16,
    parameter int unsigned STRIDE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic [AW-1:0] base_in,
    input  logic          step,
    input  logic          wrap,
    output logic [AW-1:0] ptr
);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [AW-1:0] cur;
    } ptr_regs_t;

    ptr_regs_t q, d;

    always_comb begin
        d = q;
        if (reload) begin
            d.base = base_in;
            d.cur  = base_in;
        end else if (step) begin
            d.cur = wrap ? q.base : q.cur + AW'(STRIDE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ptr = q.cur;

endmodule

// File: rtl/rxr_stat_fmt.sv
module rxr_stat_fmt
    import rxr_pkg::*;
#(
    parameter int unsigned LEN_W = 12
) (
    input  logic             first,
    input  logic             last,
    input  logic [LEN_W-1:0] len,
    input  rxr_class_t       cls,
    output logic [31:0]      word
);

    always_comb begin
        word          = '0;
        word[SOF_BIT] = first;
        word[EOF_BIT] = last;
        if (last) begin
            word[LEN_W-1:0] = len;
            word[BCAST_BIT] = cls.bcast;
            word[TYPE_BIT]  = cls.type_hit;
            for (int k = 0; k < int'(HIT_N); k++) begin
                word[HIT1_BIT-k] = cls.hit[k];
            end
        end
    end

endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
    import rxr_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned BUF_BYTES = 128,
    parameter int unsigned LEN_W     = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_en,
    input  logic [AW-1:0] ring_base,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          in_bcast,
    input  logic [3:0]    in_addr_hit,
    input  logic          in_type_hit,
    output logic          in_ready,
    output logic          desc_rd_en,
    output logic [AW-1:0] desc_rd_addr,
    input  logic [31:0]   desc_rd_data,
    output logic          desc_wr_en,
    output logic [AW-1:0] desc_wr_addr,
    output logic [31:0]   desc_wr_data,
    output logic          buf_wr_en,
    output logic [31:0]   buf_wr_addr,
    output logic [7:0]    buf_wr_data,
    output logic          no_buf_sticky
);

    localparam int unsigned OFF_W       = $clog2(BUF_BYTES);
    localparam int unsigned DESC_STRIDE = 8;
    localparam int unsigned STAT_OFS    = 4;

    typedef struct packed {
        rxr_state_e       st;
        logic [OFF_W-1:0] off;
        logic [LEN_W-1:0] len;
        logic [31:0]      w0;
        logic             first;
        logic             last;
        rxr_class_t       cls;
        logic             bna;
        logic             en;
    } regs_t;

    localparam regs_t RESET_Q = '{
        st:    ST_IDLE,
        off:   '0,
        len:   '0,
        w0:    '0,
        first: 1'b0,
        last:  1'b0,
        cls:   '0,
        bna:   1'b0,
        en:    1'b0
    };

    regs_t         q, d;
    logic          reload;
    logic          step;
    logic [AW-1:0] ptr;
    logic [31:0]   stat_word;

    assign reload = rx_en && !q.en;

    rxr_ring_ptr #(
        .AW     (AW),
        .STRIDE (DESC_STRIDE)
    ) i_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (reload),
        .base_in (ring_base),
        .step    (step),
        .wrap    (q.w0[WRAP_BIT]),
        .ptr     (ptr)
    );

    rxr_stat_fmt #(
        .LEN_W (LEN_W)
    ) i_fmt (
        .first (q.first),
        .last  (q.last),
        .len   (q.len),
        .cls   (q.cls),
        .word  (stat_word)
    );

    always_comb begin
        d            = q;
        d.en         = rx_en;
        step         = 1'b0;
        in_ready     = 1'b0;
        desc_rd_en   = 1'b0;
        desc_rd_addr = ptr;
        desc_wr_en   = 1'b0;
        desc_wr_addr = ptr;
        desc_wr_data = '0;
        buf_wr_en    = 1'b0;
        buf_wr_addr  = {q.w0[31:2], 2'b00} + 32'(q.off);
        buf_wr_data  = in_data;

        if (reload) begin
            d.bna = 1'b0;
        end

        case (q.st)
            ST_IDLE: begin
                if (rx_en && in_valid) begin
                    d.st    = ST_FETCH;
                    d.first = 1'b1;
                    d.len   = '0;
                end
            end
            ST_FETCH: begin
                desc_rd_en = 1'b1;
                d.st       = ST_CHECK;
            end
            ST_CHECK: begin
                if (desc_rd_data[OWN_BIT]) begin
                    d.bna = 1'b1;
                    d.st  = ST_DROP;
                end else begin
                    d.w0   = desc_rd_data;
                    d.off  = '0;
                    d.last = 1'b0;
                    d.st   = ST_DATA;
                end
            end
            ST_DATA: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    buf_wr_en = 1'b1;
                    d.len     = q.len + 1'b1;
                    d.off     = q.off + 1'b1;
                    if (in_last) begin
                        d.last         = 1'b1;
                        d.cls.bcast    = in_bcast;
                        d.cls.hit      = in_addr_hit;
                        d.cls.type_hit = in_type_hit;
                        d.st           = ST_WB_STAT;
                    end else if (q.off == OFF_W'(BUF_BYTES - 1)) begin
                        d.st = ST_WB_STAT;
                    end
                end
            end
            ST_WB_STAT: begin
                desc_wr_en   = 1'b1;
                desc_wr_addr = ptr + AW'(STAT_OFS);
                desc_wr_data = stat_word;
                d.st         = ST_WB_OWN;
            end
            ST_WB_OWN: begin
                desc_wr_en   = 1'b1;
                desc_wr_data = q.w0 | 32'd1;
                step         = 1'b1;
                d.first      = 1'b0;
                d.st         = q.last ? ST_IDLE : ST_FETCH;
            end
            ST_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_last) begin
                    d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_Q;
        end else begin
            q <= d;
        end
    end

    assign no_buf_sticky = q.bna;

endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
    parameter int unsigned AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_en,
    input logic          in_valid,
    input logic          in_ready,
    input logic          desc_rd_en,
    input logic [AW-1:0] desc_rd_addr,
    input logic          desc_wr_en,
    input logic [AW-1:0] desc_wr_addr,
    input logic [31:0]   desc_wr_data,
    input logic          buf_wr_en,
    input logic          no_buf_sticky
);

    AST_OWN_AFTER_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_en && !desc_wr_addr[2]) |-> ($past(desc_wr_en) && $past(desc_wr_addr) == desc_wr_addr + AW'(4))); // R7

    AST_OWN_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_en && !desc_wr_addr[2]) |-> desc_wr_data[0]); // R7

    AST_STAT_THEN_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_wr_en && desc_wr_addr[2]) |=> (desc_wr_en && desc_wr_addr == $past(desc_wr_addr) - AW'(4))); // R4

    AST_BUF_WR_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> (in_valid && in_ready)); // R3

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd_en |-> (desc_rd_addr[2:0] == 3'd0)); // R4

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_rd_en && (desc_wr_en || buf_wr_en))); // R4

    AST_NO_BUF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (no_buf_sticky && !(rx_en && !$past(rx_en))) |=> no_buf_sticky); // R9

endmodule

bind rx_ring_writer rx_ring_writer_chk #(.AW(AW)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .in_valid      (in_valid),
    .in_ready      (in_ready),
    .desc_rd_en    (desc_rd_en),
    .desc_rd_addr  (desc_rd_addr),
    .desc_wr_en    (desc_wr_en),
    .desc_wr_addr  (desc_wr_addr),
    .desc_wr_data  (desc_wr_data),
    .buf_wr_en     (buf_wr_en),
    .no_buf_sticky (no_buf_sticky)
);

// File: tb/test_rx_ring_writer.sv
module test_rx_ring_writer;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_en = 1'b0;
    logic [AW-1:0] ring_base = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_last = 1'b0;
    logic          in_bcast = 1'b0;
    logic [3:0]    in_addr_hit = '0;
    logic          in_type_hit = 1'b0;
    logic          in_ready;
    logic          desc_rd_en;
    logic [AW-1:0] desc_rd_addr;
    logic [31:0]   desc_rd_data = '0;
    logic          desc_wr_en;
    logic [AW-1:0] desc_wr_addr;
    logic [31:0]   desc_wr_data;
    logic          buf_wr_en;
    logic [31:0]   buf_wr_addr;
    logic [7:0]    buf_wr_data;
    logic          no_buf_sticky;

    logic [31:0]   desc_mem [16];
    logic [7:0]    buf_mem  [1024];
    logic          host_we = 1'b0;
    logic [3:0]    host_idx = '0;
    logic [31:0]   host_val = '0;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_ring_writer #(.AW(AW)) i_rx_ring_writer (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_en         (rx_en),
        .ring_base     (ring_base),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_last       (in_last),
        .in_bcast      (in_bcast),
        .in_addr_hit   (in_addr_hit),
        .in_type_hit   (in_type_hit),
        .in_ready      (in_ready),
        .desc_rd_en    (desc_rd_en),
        .desc_rd_addr  (desc_rd_addr),
        .desc_rd_data  (desc_rd_data),
        .desc_wr_en    (desc_wr_en),
        .desc_wr_addr  (desc_wr_addr),
        .desc_wr_data  (desc_wr_data),
        .buf_wr_en     (buf_wr_en),
        .buf_wr_addr   (buf_wr_addr),
        .buf_wr_data   (buf_wr_data),
        .no_buf_sticky (no_buf_sticky)
    );

    always @(posedge clk) begin
        if (desc_rd_en) desc_rd_data <= desc_mem[desc_rd_addr[5:2]];
        if (desc_wr_en) desc_mem[desc_wr_addr[5:2]] <= desc_wr_data;
        if (host_we) desc_mem[host_idx] <= host_val;
        if (buf_wr_en) buf_mem[buf_wr_addr[9:0]] <= buf_wr_data;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_word(input int idx, input logic [31:0] val);
        @(negedge clk);
        host_we  = 1'b1;
        host_idx = 4'(idx);
        host_val = val;
        @(negedge clk);
        host_we  = 1'b0;
    endtask

    task automatic set_desc(input int n, input logic [31:0] w0, input logic [31:0] w1);
        set_word(2*n, w0);
        set_word(2*n + 1, w1);
    endtask

    task automatic send_frame(input int n, input logic [7:0] seed, input logic bc,
                              input logic [3:0] hit, input logic th);
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            in_valid    = 1'b1;
            in_data     = seed + 8'(i);
            in_last     = (i == n - 1);
            in_bcast    = bc;
            in_addr_hit = hit;
            in_type_hit = th;
            while (!in_ready) @(negedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic chk_bytes(input string req, input int base, input int first_idx,
                             input int cnt, input logic [7:0] seed);
        int errs = 0;
        for (int k = 0; k < cnt; k++) begin
            if (buf_mem[base + k] !== seed + 8'(first_idx + k)) errs++;
        end
        chk(req, 32'(errs), 32'd0);
    endtask

    task automatic restart(input logic [AW-1:0] base);
        @(negedge clk);
        rx_en = 1'b0;
        @(negedge clk);
        ring_base = base;
        rx_en     = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 in_ready", 32'(in_ready), 0);
        chk("R1 rd/wr", {29'd0, desc_rd_en, desc_wr_en, buf_wr_en}, 0);
        chk("R1 no_buf", 32'(no_buf_sticky), 0);
    endtask

    task automatic t_disabled;
        int seen = 0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h55;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (in_ready || desc_rd_en || desc_wr_en) seen++;
        end
        in_valid = 1'b0;
        chk("R12 idle while disabled", 32'(seen), 0);
        chk("R12 desc untouched", desc_mem[0], 32'h100);
    endtask

    task automatic t_single;
        send_frame(60, 8'h10, 1'b1, 4'b0000, 1'b0);
        chk("R5 R6 single status", desc_mem[1], 32'h8000_C03C);
        chk("R7 single owned", desc_mem[0], 32'h0000_0101);
        chk_bytes("R3 R2 single bytes", 'h100, 0, 60, 8'h10);
    endtask

    task automatic t_chain;
        send_frame(200, 8'h40, 1'b0, 4'b0010, 1'b1);
        chk("R5 chain first status", desc_mem[3], 32'h0000_4000);
        chk("R7 chain first owned", desc_mem[2], 32'h0000_0181);
        chk("R5 R6 chain last status", desc_mem[5], 32'h0240_80C8);
        chk_bytes("R4 chain buf1", 'h180, 0, 128, 8'h40);
        chk_bytes("R4 chain buf2", 'h200, 128, 72, 8'h40);
    endtask

    task automatic t_wrap_desc;
        send_frame(10, 8'h90, 1'b0, 4'b1001, 1'b0);
        chk("R6 hit1/hit4 status", desc_mem[7], 32'h0480_C00A);
        chk("R7 wrap desc owned", desc_mem[6], 32'h0000_0283);
        chk_bytes("R3 masked address", 'h280, 0, 10, 8'h90);
    endtask

    task automatic t_drop_start;
        send_frame(20, 8'hA0, 1'b0, 4'b0000, 1'b0);
        chk("R9 no_buf set", 32'(no_buf_sticky), 1);
        chk("R8 R9 wrapped desc untouched w0", desc_mem[0], 32'h0000_0101);
        chk("R9 wrapped desc untouched w1", desc_mem[1], 32'h8000_C03C);
        chk("R9 buffer untouched", 32'(buf_mem['h100]), 32'h10);
        repeat (5) @(negedge clk);
        chk("R9 still sticky", 32'(no_buf_sticky), 1);
    endtask

    task automatic t_drop_mid;
        set_desc(0, 32'h100, 0);
        set_desc(1, 32'h180, 0);
        set_desc(2, 32'h200, 0);
        restart(16'h0008);
        chk("R9 cleared by enable rise", 32'(no_buf_sticky), 0);
        send_frame(300, 8'h20, 1'b1, 4'b0000, 1'b0);
        chk("R2 R10 first buffer status", desc_mem[3], 32'h0000_4000);
        chk("R10 first buffer owned", desc_mem[2], 32'h0000_0181);
        chk("R10 middle buffer status", desc_mem[5], 32'h0000_0000);
        chk("R10 middle buffer owned", desc_mem[4], 32'h0000_0201);
        chk("R10 no_buf set", 32'(no_buf_sticky), 1);
        chk("R10 owned desc untouched", desc_mem[7], 32'h0480_C00A);
        chk("R2 desc0 unused", desc_mem[0], 32'h0000_0100);
        chk_bytes("R10 middle buffer bytes", 'h200, 128, 128, 8'h20);
    endtask

    task automatic t_next_frame;
        set_desc(0, 32'h100, 0);
        set_desc(1, 32'h180, 0);
        set_desc(2, 32'h200, 0);
        set_desc(3, 32'h282, 0);
        restart(16'h0000);
        send_frame(5, 8'h01, 1'b0, 4'b0000, 1'b0);
        send_frame(7, 8'h61, 1'b0, 4'b0000, 1'b0);
        chk("R11 first short status", desc_mem[1], 32'h0000_C005);
        chk("R11 second in next desc", desc_mem[3], 32'h0000_C007);
        chk("R11 second owned", desc_mem[2], 32'h0000_0181);
        chk("R11 second buffer byte0", 32'(buf_mem['h180]), 32'h61);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        set_desc(0, 32'h100, 0);
        set_desc(1, 32'h180, 0);
        set_desc(2, 32'h200, 0);
        set_desc(3, 32'h282, 0);
        t_disabled();
        restart(16'h0000);
        t_single();
        t_chain();
        t_wrap_desc();
        t_drop_start();
        t_drop_mid();
        t_next_frame();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule